// File: doc/BRIEF.md
# DQS Timing Window Calibrator

This engine trains the data-strobe timing of a DDR2 memory controller. It runs a two-level sweep. The outer axis steps the write-strobe shift. A companion output shift always sits 32 steps above it. The inner axis steps a read-strobe delay that is applied identically to every byte lane. For each setting the engine drops the controller start bit, programs the delays and raises start again. It then waits for the delay-line lock flag and the initialisation-complete flag, and lets a settling period pass. After that it writes a fixed set of test words through a simple memory port and reads every word back several times.

A setting passes only if every read matches. Consecutive passing read delays form a window. The engine keeps the longest window found over the whole sweep, and a later window of equal length replaces an earlier one. It then programs the write shift of that window and the midpoint of its read delays, restarts the controller and pulses done. If no setting ever passes, done comes with a no-window flag. A handshake that never arrives halts the sweep with an error flag.

Top module: `dqs_cal_top`

## Requirements
- R1: The write shift sweeps from SHIFT_LO to SHIFT_HI inclusive, and while start is high the output shift always equals the write shift plus 32.
- R2: The read delay sweeps from DLY_LO to DLY_HI inclusive for each write shift, and all LANES fields of `rd_dly_o` carry the same value; lane n occupies bits [n*DLY_W +: DLY_W].
- R3: Delay and shift fields change only while `ctl_start_o` is low. Start is raised after programming, and the engine waits for `dll_lock_i` and then for `init_done_i`.
- R4: If a handshake flag stays low for POLL_LIMIT polls, the engine sets `err_lock_o` or `err_init_o`, stops the sweep, drops busy and never pulses done.
- R5: After init-complete the engine waits CLK_MHZ*SETTLE_US cycles before the first memory write of that setting.
- R6: Each setting writes NWORDS 32-bit words to addresses 0 upward, and every write comes before any read. Word j is P if ((j>>1)^(j>>3)) is even and ~P if it is odd, where P is 0x00000000, 0xAAAAAAAA, 0xA5A5A5A5 or 0xAA55AA55 for (j>>4)%4 = 0, 1, 2 or 3. The read port returns data one cycle after a read request.
- R7: Every word is read NREADS times. A single mismatch fails the setting and skips the remaining reads.
- R8: A pass extends the current run and records the run start on its first pass. A fail clears the run, and the run is also cleared at each new write shift.
- R9: When the run length is greater than or equal to the best so far, the best count, the write shift, the run start and the current delay are recorded, so a later window of equal length wins.
- R10: When a window exists, the engine programs the best write shift (output shift +32) and the read delay floor((start+end)/2) on all lanes. It then raises start and pulses `done_o` for exactly one cycle.
- R11: When no setting passes, `done_o` pulses with `err_nowin_o` set, start stays low, and the write shift and read delay keep their last swept values (SHIFT_HI, DLY_HI).
- R12: `best_cnt_o`, `best_shift_o`, `win_start_o` and `win_end_o` show the recorded best window after done.
- R13: After reset, busy, done, all error flags, start and the memory request are low, and the best count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_go_i | input | 1 | Starts a calibration run when idle or halted |
| busy_o | output | 1 | A sweep is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_lock_o | output | 1 | Delay-line lock timeout, sweep halted |
| err_init_o | output | 1 | Init-complete timeout, sweep halted |
| err_nowin_o | output | 1 | Sweep finished without any passing setting |
| ctl_start_o | output | 1 | Controller start bit |
| wr_shift_o | output | SHIFT_W | Write-strobe shift field |
| out_shift_o | output | SHIFT_W | Strobe output shift field |
| rd_dly_o | output | LANES*DLY_W | Per-lane read-strobe delay fields |
| dll_lock_i | input | 1 | Delay-line lock flag |
| init_done_i | input | 1 | Controller init-complete flag |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| best_cnt_o | output | CW | Length of the best window |
| best_shift_o | output | SHIFT_W | Write shift of the best window |
| win_start_o | output | DLY_W | First read delay of the best window |
| win_end_o | output | DLY_W | Last read delay of the best window |

## Verification
The behavioural memory corrupts only the final repetition of the last word. A design that skips reads or words therefore scores failing settings as passes and reports a window that is too long. Equal-length windows, placed across two shifts and inside one shift, catch a strict greater-than comparison, which would keep the earlier window. A short run at the end of one shift followed by a short run at the start of the next catches a run counter that is not cleared between shifts, which would join the two runs. Stuck handshake flags and a sweep with no passing setting check that the engine halts without done and leaves the last swept values in place rather than programming a bogus midpoint.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SHIFT, ST_PROG, ST_ARM, ST_LOCK, ST_INIT, ST_SETTLE,
    ST_WRITE, ST_READ, ST_CHECK, ST_SCORE, ST_FINISH, ST_LAUNCH, ST_HALT
  } cal_state_e;

  // Training word for index idx: a base value per group of 16 words,
  // inverted in alternating two-word groups.
  function automatic logic [31:0] train_word(input int unsigned idx);
    logic [31:0] base;
    logic        flip;
    case ((idx >> 4) & 3)
      0:       base = 32'h0000_0000;
      1:       base = 32'hAAAA_AAAA;
      2:       base = 32'hA5A5_A5A5;
      default: base = 32'hAA55_AA55;
    endcase
    flip = 1'(((idx >> 1) ^ (idx >> 3)) & 1);
    return flip ? ~base : base;
  endfunction

  // Centre of a window, rounded down.
  function automatic int unsigned window_mid(input int unsigned first,
                                             input int unsigned last);
    return (first + last) / 2;
  endfunction

endpackage

// File: rtl/dqs_cycle_timer.sv
module dqs_cycle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  assign expired_o = (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clear)              cnt_q <= '0;
    else if (run && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dqs_window_tracker.sv
module dqs_window_tracker #(
  parameter int unsigned SHIFT_W = 7,
  parameter int unsigned DLY_W   = 7,
  parameter int unsigned CW      = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic               clr_run,
  input  logic               score,
  input  logic               pass,
  input  logic [SHIFT_W-1:0] cur_shift,
  input  logic [DLY_W-1:0]   cur_dly,
  output logic [CW-1:0]      run_cnt_o,
  output logic [CW-1:0]      best_cnt_o,
  output logic [SHIFT_W-1:0] best_shift_o,
  output logic [DLY_W-1:0]   best_start_o,
  output logic [DLY_W-1:0]   best_end_o
);
  logic [CW-1:0]    run_q, run_next;
  logic [DLY_W-1:0] run_start_q, start_next;
  logic             take;

  always_comb begin
    run_next   = run_q + 1'b1;
    start_next = (run_q == '0) ? cur_dly : run_start_q;
    take       = score && pass && (run_next >= best_cnt_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0; run_start_q <= '0;
      best_cnt_o <= '0; best_shift_o <= '0; best_start_o <= '0; best_end_o <= '0;
    end else if (clr_all) begin
      run_q <= '0; run_start_q <= '0;
      best_cnt_o <= '0; best_shift_o <= '0; best_start_o <= '0; best_end_o <= '0;
    end else begin
      if (clr_run) run_q <= '0;
      else if (score) begin
        if (pass) begin
          run_q       <= run_next;
          run_start_q <= start_next;
        end else begin
          run_q <= '0;
        end
      end
      if (take) begin
        best_cnt_o   <= run_next;
        best_shift_o <= cur_shift;
        best_start_o <= start_next;
        best_end_o   <= cur_dly;
      end
    end
  end

  assign run_cnt_o = run_q;
endmodule

// File: rtl/dqs_lane_fanout.sv
module dqs_lane_fanout #(
  parameter int unsigned LANES = 9,
  parameter int unsigned DLY_W = 7
) (
  input  logic [DLY_W-1:0]       dly_i,
  output logic [LANES*DLY_W-1:0] lanes_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes_o[g*DLY_W +: DLY_W] = dly_i;
  end
endmodule

// File: rtl/dqs_cal_top.sv
module dqs_cal_top
  import dqs_cal_pkg::*;
#(
  parameter int unsigned SHIFT_LO   = 64,
  parameter int unsigned SHIFT_HI   = 95,
  parameter int unsigned DLY_LO     = 1,
  parameter int unsigned DLY_HI     = 63,
  parameter int unsigned LANES      = 9,
  parameter int unsigned SHIFT_W    = 7,
  parameter int unsigned DLY_W      = 7,
  parameter int unsigned NWORDS     = 64,
  parameter int unsigned NREADS     = 10,
  parameter int unsigned POLL_LIMIT = 65535,
  parameter int unsigned CLK_MHZ    = 100,
  parameter int unsigned SETTLE_US  = 100,
  localparam int unsigned AW        = $clog2(NWORDS),
  localparam int unsigned CW        = $clog2(DLY_HI - DLY_LO + 2)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cal_go_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_lock_o,
  output logic                   err_init_o,
  output logic                   err_nowin_o,
  output logic                   ctl_start_o,
  output logic [SHIFT_W-1:0]     wr_shift_o,
  output logic [SHIFT_W-1:0]     out_shift_o,
  output logic [LANES*DLY_W-1:0] rd_dly_o,
  input  logic                   dll_lock_i,
  input  logic                   init_done_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [31:0]            mem_wdata_o,
  input  logic [31:0]            mem_rdata_i,
  output logic [CW-1:0]          best_cnt_o,
  output logic [SHIFT_W-1:0]     best_shift_o,
  output logic [DLY_W-1:0]       win_start_o,
  output logic [DLY_W-1:0]       win_end_o
);
  localparam int unsigned SETTLE = CLK_MHZ * SETTLE_US;
  localparam int unsigned RW     = $clog2(NREADS + 1);
  localparam logic [SHIFT_W-1:0] SH_LO  = SHIFT_W'(SHIFT_LO);
  localparam logic [SHIFT_W-1:0] SH_HI  = SHIFT_W'(SHIFT_HI);
  localparam logic [SHIFT_W-1:0] SH_OFS = SHIFT_W'(32);
  localparam logic [DLY_W-1:0]   DL_LO  = DLY_W'(DLY_LO);
  localparam logic [DLY_W-1:0]   DL_HI  = DLY_W'(DLY_HI);
  localparam logic [AW-1:0]      LAST_W = AW'(NWORDS - 1);
  localparam logic [RW-1:0]      LAST_R = RW'(NREADS - 1);

  cal_state_e         state_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [DLY_W-1:0]   dly_q, dly_cfg_q;
  logic [AW-1:0]      idx_q;
  logic [RW-1:0]      rep_q;
  logic               pass_q;
  logic               poll_exp, settle_exp;
  logic [CW-1:0]      run_cnt;

  // Named internal events for the checker.
  logic ev_clear_all, ev_clear_run, ev_score, ev_pass, rd_phase, mismatch;
  assign ev_clear_all = cal_go_i && (state_q == ST_IDLE || state_q == ST_HALT);
  assign ev_clear_run = (state_q == ST_SHIFT);
  assign ev_score     = (state_q == ST_SCORE);
  assign ev_pass      = pass_q;
  assign rd_phase     = (state_q == ST_READ) || (state_q == ST_CHECK);
  assign mismatch     = (mem_rdata_i != train_word(32'(idx_q)));

  dqs_cycle_timer #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .clear(!(state_q == ST_LOCK || state_q == ST_INIT) ||
           (state_q == ST_LOCK && dll_lock_i)),
    .run(state_q == ST_LOCK || state_q == ST_INIT),
    .expired_o(poll_exp));

  dqs_cycle_timer #(.LIMIT(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n),
    .clear(state_q != ST_SETTLE), .run(state_q == ST_SETTLE),
    .expired_o(settle_exp));

  dqs_window_tracker #(.SHIFT_W(SHIFT_W), .DLY_W(DLY_W), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .clr_all(ev_clear_all), .clr_run(ev_clear_run),
    .score(ev_score), .pass(pass_q),
    .cur_shift(shift_q), .cur_dly(dly_q),
    .run_cnt_o(run_cnt), .best_cnt_o(best_cnt_o), .best_shift_o(best_shift_o),
    .best_start_o(win_start_o), .best_end_o(win_end_o));

  dqs_lane_fanout #(.LANES(LANES), .DLY_W(DLY_W)) u_fan (
    .dly_i(dly_cfg_q), .lanes_o(rd_dly_o));

  assign busy_o      = !(state_q == ST_IDLE || state_q == ST_HALT);
  assign mem_req_o   = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = idx_q;
  assign mem_wdata_o = train_word(32'(idx_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; shift_q <= '0; dly_q <= '0; dly_cfg_q <= '0;
      idx_q <= '0; rep_q <= '0; pass_q <= 1'b0; ctl_start_o <= 1'b0;
      wr_shift_o <= '0; out_shift_o <= '0; done_o <= 1'b0;
      err_lock_o <= 1'b0; err_init_o <= 1'b0; err_nowin_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE, ST_HALT: if (cal_go_i) begin
          err_lock_o <= 1'b0; err_init_o <= 1'b0; err_nowin_o <= 1'b0;
          shift_q <= SH_LO;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          ctl_start_o <= 1'b0;
          wr_shift_o  <= shift_q;
          out_shift_o <= shift_q + SH_OFS;
          dly_q       <= DL_LO;
          state_q     <= ST_PROG;
        end
        ST_PROG: begin
          ctl_start_o <= 1'b0;
          dly_cfg_q   <= dly_q;
          state_q     <= ST_ARM;
        end
        ST_ARM: begin
          ctl_start_o <= 1'b1;
          state_q     <= ST_LOCK;
        end
        ST_LOCK:
          if (dll_lock_i) state_q <= ST_INIT;
          else if (poll_exp) begin err_lock_o <= 1'b1; state_q <= ST_HALT; end
        ST_INIT:
          if (init_done_i) state_q <= ST_SETTLE;
          else if (poll_exp) begin err_init_o <= 1'b1; state_q <= ST_HALT; end
        ST_SETTLE: if (settle_exp) begin idx_q <= '0; state_q <= ST_WRITE; end
        ST_WRITE:
          if (idx_q == LAST_W) begin idx_q <= '0; rep_q <= '0; state_q <= ST_READ; end
          else idx_q <= idx_q + 1'b1;
        ST_READ: state_q <= ST_CHECK;
        ST_CHECK:
          if (mismatch) begin pass_q <= 1'b0; state_q <= ST_SCORE; end
          else if (rep_q != LAST_R) begin rep_q <= rep_q + 1'b1; state_q <= ST_READ; end
          else if (idx_q == LAST_W) begin pass_q <= 1'b1; state_q <= ST_SCORE; end
          else begin idx_q <= idx_q + 1'b1; rep_q <= '0; state_q <= ST_READ; end
        ST_SCORE: begin
          ctl_start_o <= 1'b0;
          if (dly_q != DL_HI) begin dly_q <= dly_q + 1'b1; state_q <= ST_PROG; end
          else if (shift_q != SH_HI) begin shift_q <= shift_q + 1'b1; state_q <= ST_SHIFT; end
          else state_q <= ST_FINISH;
        end
        ST_FINISH:
          if (best_cnt_o == '0) begin
            err_nowin_o <= 1'b1; done_o <= 1'b1; state_q <= ST_IDLE;
          end else begin
            wr_shift_o  <= best_shift_o;
            out_shift_o <= best_shift_o + SH_OFS;
            dly_cfg_q   <= DLY_W'(window_mid(32'(win_start_o), 32'(win_end_o)));
            state_q     <= ST_LAUNCH;
          end
        ST_LAUNCH: begin
          ctl_start_o <= 1'b1; done_o <= 1'b1; state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dqs_cal_chk.sv
module dqs_cal_chk #(
  parameter int unsigned SHIFT_W = 7,
  parameter int unsigned DLY_W   = 7,
  parameter int unsigned LANES   = 9,
  parameter int unsigned CW      = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctl_start_o,
  input logic [SHIFT_W-1:0]     wr_shift_o,
  input logic [SHIFT_W-1:0]     out_shift_o,
  input logic [LANES*DLY_W-1:0] rd_dly_o,
  input logic                   done_o,
  input logic                   mem_req_o,
  input logic                   mem_we_o,
  input logic                   err_lock_o,
  input logic                   err_init_o,
  input logic [CW-1:0]          best_cnt_o,
  input logic [CW-1:0]          run_cnt,
  input logic                   rd_phase,
  input logic                   ev_score,
  input logic                   ev_pass,
  input logic                   ev_clear_all
);
  logic lanes_same;
  always_comb begin
    lanes_same = 1'b1;
    for (int n = 1; n < LANES; n++)
      if (rd_dly_o[n*DLY_W +: DLY_W] != rd_dly_o[DLY_W-1:0]) lanes_same = 1'b0;
  end

  assert_out_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start_o |-> (out_shift_o == SHIFT_W'(wr_shift_o + SHIFT_W'(32))));

  assert_lanes_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lanes_same);

  assert_prog_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rd_dly_o) || !$stable(wr_shift_o)) |-> !ctl_start_o);

  assert_halt_no_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_lock_o || err_init_o) |-> !done_o);

  assert_no_write_in_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |-> !(mem_req_o && mem_we_o));

  assert_fail_clears_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_score && !ev_pass) |=> (run_cnt == '0));

  assert_best_never_shrinks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_clear_all |=> (best_cnt_o >= $past(best_cnt_o)));

  assert_done_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind dqs_cal_top dqs_cal_chk #(
  .SHIFT_W(SHIFT_W), .DLY_W(DLY_W), .LANES(LANES), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_start_o(ctl_start_o), .wr_shift_o(wr_shift_o),
  .out_shift_o(out_shift_o), .rd_dly_o(rd_dly_o), .done_o(done_o),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .err_lock_o(err_lock_o),
  .err_init_o(err_init_o), .best_cnt_o(best_cnt_o), .run_cnt(run_cnt),
  .rd_phase(rd_phase), .ev_score(ev_score), .ev_pass(ev_pass),
  .ev_clear_all(ev_clear_all)
);

// File: tb/sim_dqs_cal_top.sv
module sim_dqs_cal_top;
  localparam int SH_LO = 64, SH_HI = 66, DL_LO = 1, DL_HI = 8;
  localparam int LANES = 9, SW = 7, DW = 7, NW = 64, NR = 2, POLL = 20;
  localparam int SETTLE = 100;  // 100 MHz x 1 us
  localparam int AW = 6, CW = 4;

  typedef struct packed {
    logic [7:0] lo0, hi0, h0, lo1, hi1, h1, lo2, hi2, h2;
    logic [7:0] cnt, sh, st, en, mid, nowin;
  } vec_t;

  // Pass windows per shift (lo=0: none, h: single failing delay) and results.
  localparam vec_t VEC [7] = '{
    '{8'd2, 8'd4, 8'd0, 8'd3, 8'd7, 8'd0, 8'd0, 8'd0, 8'd0, 8'd5, 8'd65, 8'd3, 8'd7, 8'd5, 8'd0},
    '{8'd1, 8'd4, 8'd0, 8'd5, 8'd8, 8'd0, 8'd0, 8'd0, 8'd0, 8'd4, 8'd65, 8'd5, 8'd8, 8'd6, 8'd0},
    '{8'd1, 8'd3, 8'd0, 8'd0, 8'd0, 8'd0, 8'd5, 8'd8, 8'd0, 8'd4, 8'd66, 8'd5, 8'd8, 8'd6, 8'd0},
    '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0, 8'd0, 8'd8, 8'd1},
    '{8'd1, 8'd8, 8'd0, 8'd1, 8'd8, 8'd0, 8'd1, 8'd8, 8'd0, 8'd8, 8'd66, 8'd1, 8'd8, 8'd4, 8'd0},
    '{8'd1, 8'd7, 8'd4, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd3, 8'd64, 8'd5, 8'd7, 8'd6, 8'd0},
    '{8'd6, 8'd8, 8'd0, 8'd1, 8'd2, 8'd0, 8'd0, 8'd0, 8'd0, 8'd3, 8'd64, 8'd6, 8'd8, 8'd7, 8'd0}
  };

  logic clk = 0, rst_n = 0, go = 0;
  logic busy, done, e_lock, e_init, e_nowin, cstart, lock, initd;
  logic [SW-1:0] wsh, osh, bsh;
  logic [LANES*DW-1:0] rdly;
  logic mreq, mwe;
  logic [AW-1:0] maddr;
  logic [31:0] mwd, mrd;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] wst, wen;

  always #5 clk = ~clk;

  dqs_cal_top #(.SHIFT_LO(SH_LO), .SHIFT_HI(SH_HI), .DLY_LO(DL_LO), .DLY_HI(DL_HI),
    .LANES(LANES), .SHIFT_W(SW), .DLY_W(DW), .NWORDS(NW), .NREADS(NR),
    .POLL_LIMIT(POLL), .CLK_MHZ(100), .SETTLE_US(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cal_go_i(go), .busy_o(busy), .done_o(done),
    .err_lock_o(e_lock), .err_init_o(e_init), .err_nowin_o(e_nowin),
    .ctl_start_o(cstart), .wr_shift_o(wsh), .out_shift_o(osh), .rd_dly_o(rdly),
    .dll_lock_i(lock), .init_done_i(initd), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_wdata_o(mwd), .mem_rdata_i(mrd),
    .best_cnt_o(bcnt), .best_shift_o(bsh), .win_start_o(wst), .win_end_o(wen));

  int checks = 0, failures = 0, cyc = 0;
  vec_t cur;
  logic lock_stuck = 0, init_stuck = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected word, restated: pair selected by index bits 5:4, complement on
  // positions 2,3,6,7 of each 8-block, swapped in odd 8-blocks.
  function automatic logic [31:0] exp_word(input int j);
    logic [31:0] p [4] = '{32'h0, 32'hAAAAAAAA, 32'hA5A5A5A5, 32'hAA55AA55};
    int pos = j % 8;
    bit inv = ((pos / 2) % 2 == 1) != ((j / 8) % 2 == 1);
    return inv ? ~p[(j / 16) % 4] : p[(j / 16) % 4];
  endfunction

  function automatic bit setting_ok(input int sh, input int d);
    int lo, hi, h;
    case (sh)
      64: begin lo = cur.lo0; hi = cur.hi0; h = cur.h0; end
      65: begin lo = cur.lo1; hi = cur.hi1; h = cur.h1; end
      default: begin lo = cur.lo2; hi = cur.hi2; h = cur.h2; end
    endcase
    return lo != 0 && d >= lo && d <= hi && d != h;
  endfunction

  // Controller handshake model.
  int hs = 0;
  always @(posedge clk) hs <= cstart ? hs + 1 : 0;
  assign lock  = cstart && hs >= 3 && !lock_stuck;
  assign initd = cstart && hs >= 6 && !init_stuck;

  // Behavioural memory: a failing setting corrupts only the last repetition
  // of the last word.
  logic [31:0] mem [NW];
  int rcnt [NW];
  int wr_bad = 0, order_bad = 0, done_cnt = 0, lane_bad = 0, osh_bad = 0;
  int min_sh = 999, max_sh = 0, min_d = 999, max_d = 0;
  int arm_t = 0, min_gap = 1 << 30;
  bit read_seen = 0, wr_pend = 0, prev_start = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_start <= cstart;
    if (cstart && !prev_start) begin arm_t = cyc; wr_pend = 1; end
    if (!cstart) read_seen = 0;
    if (done) done_cnt++;
    if (mreq && mwe) begin
      mem[maddr] <= mwd;
      rcnt[maddr] = 0;
      if (mwd !== exp_word(int'(maddr))) wr_bad++;
      if (read_seen) order_bad++;
      if (wr_pend) begin
        if (cyc - arm_t < min_gap) min_gap = cyc - arm_t;
        wr_pend = 0;
      end
    end
    if (mreq && !mwe) begin
      read_seen = 1;
      if (!setting_ok(int'(wsh), int'(rdly[DW-1:0])) && int'(maddr) == NW - 1 &&
          rcnt[maddr] == NR - 1)
        mrd <= mem[maddr] ^ 32'h1;
      else
        mrd <= mem[maddr];
      rcnt[maddr] = rcnt[maddr] + 1;
    end
  end

  always @(negedge clk) if (rst_n && cstart) begin
    if (int'(wsh) < min_sh) min_sh = int'(wsh);
    if (int'(wsh) > max_sh) max_sh = int'(wsh);
    if (int'(rdly[DW-1:0]) < min_d) min_d = int'(rdly[DW-1:0]);
    if (int'(rdly[DW-1:0]) > max_d) max_d = int'(rdly[DW-1:0]);
    for (int n = 1; n < LANES; n++)
      if (rdly[n*DW +: DW] != rdly[DW-1:0]) lane_bad++;
    if (osh != SW'(wsh + 32)) osh_bad++;
  end

  initial begin
    wait (cyc == 190000);
    failures++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic launch();
    @(negedge clk) go = 1;
    @(negedge clk) go = 0;
  endtask

  initial begin
    mrd = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!busy && !done && !e_lock && !e_init && !e_nowin, "R13 flags", busy, 0);
    chk(!cstart && !mreq && bcnt == 0, "R13 start/req/best", cstart, 0);
    rst_n = 1;
    @(negedge clk);

    // Vector table walk.
    for (int i = 0; i < 7; i++) begin
      int waited;
      cur = VEC[i];
      wr_bad = 0; order_bad = 0; done_cnt = 0; lane_bad = 0; osh_bad = 0;
      min_sh = 999; max_sh = 0; min_d = 999; max_d = 0; min_gap = 1 << 30;
      launch();
      waited = 0;
      while (!done && waited < 20000) begin @(negedge clk); waited++; end
      chk(done, "R10 done seen", done, 1);
      chk(e_nowin == cur.nowin[0], "R11 nowin flag", e_nowin, cur.nowin);
      chk(bcnt == cur.cnt[CW-1:0], "R7 R8 R9 R12 best count", bcnt, cur.cnt);
      chk(bsh == cur.sh[SW-1:0], "R9 R12 best shift", bsh, cur.sh);
      chk(wst == cur.st[DW-1:0] && wen == cur.en[DW-1:0], "R8 R12 window",
          wst * 100 + wen, cur.st * 100 + cur.en);
      chk(rdly[DW-1:0] == cur.mid[DW-1:0], "R10 R11 final delay", rdly[DW-1:0], cur.mid);
      chk(wsh == (cur.nowin[0] ? SW'(SH_HI) : cur.sh[SW-1:0]), "R10 R11 final shift",
          wsh, cur.nowin[0] ? SH_HI : cur.sh);
      chk(osh == SW'(wsh + 32) && osh_bad == 0, "R1 output shift", osh, wsh + 32);
      chk(cstart == !cur.nowin[0], "R10 R11 start", cstart, !cur.nowin[0]);
      chk(lane_bad == 0 && rdly == {LANES{rdly[DW-1:0]}}, "R2 lanes equal", lane_bad, 0);
      chk(min_sh == SH_LO && max_sh == SH_HI, "R1 shift range", min_sh * 1000 + max_sh,
          SH_LO * 1000 + SH_HI);
      chk(min_d == DL_LO && max_d == DL_HI, "R2 delay range", min_d * 1000 + max_d,
          DL_LO * 1000 + DL_HI);
      chk(wr_bad == 0, "R6 write pattern", wr_bad, 0);
      chk(order_bad == 0, "R6 writes before reads", order_bad, 0);
      chk(min_gap >= SETTLE, "R5 settle gap", min_gap, SETTLE);
      @(negedge clk);
      chk(!done && done_cnt == 1 && !busy, "R10 single done pulse", done_cnt, 1);
    end

    // R4 lock timeout.
    begin
      int waited = 0;
      lock_stuck = 1; done_cnt = 0;
      launch();
      while (busy && waited < 2000) begin @(negedge clk); waited++; end
      chk(e_lock && !e_init, "R4 lock error", e_lock, 1);
      chk(waited >= POLL, "R4 lock poll count", waited, POLL);
      chk(done_cnt == 0 && !busy, "R4 no done after lock error", done_cnt, 0);
      lock_stuck = 0;
    end
    // R4 init timeout.
    begin
      int waited = 0;
      init_stuck = 1; done_cnt = 0;
      launch();
      while (busy && waited < 2000) begin @(negedge clk); waited++; end
      chk(e_init && !e_lock, "R4 R3 init error", e_init, 1);
      chk(waited >= POLL, "R4 init poll count", waited, POLL);
      chk(done_cnt == 0, "R4 no done after init error", done_cnt, 0);
      init_stuck = 0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule